// File: doc/BRIEF.md
# Sixteen-Function 8-Bit ALU Slice

This block is a purely combinational arithmetic logic unit for two 8-bit operands. A 4-bit operation code picks one of sixteen functions. Codes with the top bit clear select the arithmetic group, and codes with the top bit set select the bitwise and shift group. The result appears on an 8-bit output, with a single carry/borrow bit beside it.

An output-enable input gates both outputs. When it is low, the result and the carry are forced to zero rather than left undefined. The slice is designed to be placed three times side by side, with identical inputs fed to each copy, under a majority voter that compares the copies. Every output bit must therefore be a defined value in every input state, including division by zero. A division never stalls, because the block holds no state.

Top module: `opsel_alu`

## Requirements
- R1: Code 0 adds: res_o = (opa_i + opb_i) mod 256, and cy_o is the carry out of bit 7.
- R2: Code 1 subtracts: res_o = (opa_i - opb_i) mod 256, and cy_o = 1 exactly when opa_i < opb_i (borrow).
- R3: Code 2 gives the low 8 bits of opa_i * opb_i. Code 3 gives the integer quotient opa_i / opb_i. Code 4 gives the remainder opa_i mod opb_i. For all three, cy_o = 0.
- R4: For code 3 or code 4 with opb_i = 0, res_o = 8'hFF and cy_o = 0, valid in the same cycle as the inputs.
- R5: Code 5 gives opa_i + 1, with cy_o = 1 exactly when opa_i = 8'hFF. Code 6 gives opa_i - 1, with cy_o = 1 exactly when opa_i = 8'h00. Both wrap modulo 256.
- R6: Code 7 shifts opa_i left by one and code 15 shifts it right by one. Both fill the vacated bit with 0, and cy_o = 0.
- R7: Codes 8 to 14 give, in order, opa_i AND opb_i, OR, NOT opa_i, XOR, NAND, NOR and XNOR, all with cy_o = 0.
- R8: When out_en_i = 0, res_o = 0 and cy_o = 0 for every operand and operation code. This includes cases that would otherwise carry or divide by zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand (divisor, subtrahend) |
| op_i | input | 4 | Operation code, 0 to 15 |
| out_en_i | input | 1 | Output enable; low forces both outputs to zero |
| res_o | output | 8 | Result |
| cy_o | output | 1 | Carry (add, increment) or borrow (subtract, decrement) |

## Verification
The enable gate and the carry or divide-by-zero paths can act on the same input combination. With enable low, an 8'hFF + 8'h01 add or a divide by zero must still produce zero on both outputs.

The bench provokes these collisions in two ways. It sweeps all sixteen codes over the corner operands 0, 8'h80 and 8'hFF with enable high and then with enable low. It also applies random operands with random enable values. Each result is judged against a reference model computed independently in the bench.

// File: rtl/opsel_alu_pkg.sv
// Shared types for the ALU slice: operation-code width and the two
// three-bit function groups selected by the low bits of the code.
package opsel_alu_pkg;
    localparam int OP_W = 4;

    typedef enum logic [2:0] {
        AR_ADD = 3'd0, AR_SUB = 3'd1, AR_MUL = 3'd2, AR_DIV = 3'd3,
        AR_MOD = 3'd4, AR_INC = 3'd5, AR_DEC = 3'd6, AR_SHL = 3'd7
    } arith_op_e;

    typedef enum logic [2:0] {
        LG_AND = 3'd0, LG_OR  = 3'd1, LG_NOTA = 3'd2, LG_XOR = 3'd3,
        LG_NAND = 3'd4, LG_NOR = 3'd5, LG_XNOR = 3'd6, LG_SHR = 3'd7
    } logic_op_e;
endpackage

// File: rtl/opsel_alu_arith.sv
// Arithmetic group (op codes 0-7). Purely combinational.
// Assumes: the caller decides whether this group is selected; a zero
// divisor yields all ones so the unit never waits or produces X.
module opsel_alu_arith
    import opsel_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [2:0]   sel_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic [W:0]   sum_w;
    logic [W:0]   dif_w;
    logic [W:0]   inc_w;
    logic [W-1:0] mul_lo;
    logic [W-1:0] quo;
    logic [W-1:0] rem;
    logic         b_zero;

    // Shared datapath pieces, each computed once.
    assign sum_w  = {1'b0, a_i} + {1'b0, b_i};
    assign dif_w  = {1'b0, a_i} - {1'b0, b_i};
    assign inc_w  = {1'b0, a_i} + {1'b0, ONE};
    assign mul_lo = a_i * b_i;
    assign b_zero = (b_i == '0);
    assign quo    = b_zero ? ALL_ONES : a_i / b_i;
    assign rem    = b_zero ? ALL_ONES : a_i % b_i;

    // Pick the arithmetic function and its carry/borrow.
    always_comb begin
        res_o = '0;
        cy_o  = 1'b0;
        case (arith_op_e'(sel_i))
            AR_ADD: begin res_o = sum_w[W-1:0]; cy_o = sum_w[W]; end
            AR_SUB: begin res_o = dif_w[W-1:0]; cy_o = dif_w[W]; end
            AR_MUL: res_o = mul_lo;
            AR_DIV: res_o = quo;
            AR_MOD: res_o = rem;
            AR_INC: begin res_o = inc_w[W-1:0]; cy_o = inc_w[W]; end
            AR_DEC: begin res_o = a_i - ONE; cy_o = (a_i == '0); end
            AR_SHL: res_o = {a_i[W-2:0], 1'b0};
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/opsel_alu_logic.sv
// Bitwise and right-shift group (op codes 8-15). Purely combinational,
// produces no carry. Assumes the caller gates selection.
module opsel_alu_logic
    import opsel_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [2:0]   sel_i,
    output logic [W-1:0] res_o
);
    // Pick the bitwise function.
    always_comb begin
        case (logic_op_e'(sel_i))
            LG_AND:  res_o = a_i & b_i;
            LG_OR:   res_o = a_i | b_i;
            LG_NOTA: res_o = ~a_i;
            LG_XOR:  res_o = a_i ^ b_i;
            LG_NAND: res_o = ~(a_i & b_i);
            LG_NOR:  res_o = ~(a_i | b_i);
            LG_XNOR: res_o = ~(a_i ^ b_i);
            LG_SHR:  res_o = {1'b0, a_i[W-1:1]};
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/opsel_alu_gate.sv
// Output gate: forces every output bit to a defined zero when disabled,
// so a downstream voter never compares floating values.
module opsel_alu_gate #(
    parameter int W = 8
) (
    input  logic [W-1:0] d_i,
    input  logic         en_i,
    output logic [W-1:0] q_o
);
    // One AND per bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign q_o[i] = d_i[i] & en_i;
    end
endmodule

// File: rtl/opsel_alu.sv
// Top of the sixteen-function ALU slice. op_i[3] selects the logic group
// over the arithmetic group; out_en_i gates result and carry together.
// Assumes: combinational use, identical inputs across redundant copies.
module opsel_alu
    import opsel_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]    opa_i,
    input  logic [W-1:0]    opb_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            out_en_i,
    output logic [W-1:0]    res_o,
    output logic            cy_o
);
    logic [W-1:0] ar_res;
    logic         ar_cy;
    logic [W-1:0] lg_res;
    logic [W:0]   pre;
    logic [W:0]   gated;

    opsel_alu_arith #(.W(W)) u_arith (
        .a_i(opa_i), .b_i(opb_i), .sel_i(op_i[2:0]),
        .res_o(ar_res), .cy_o(ar_cy)
    );

    opsel_alu_logic #(.W(W)) u_logic (
        .a_i(opa_i), .b_i(opb_i), .sel_i(op_i[2:0]), .res_o(lg_res)
    );

    // Group select; the logic group never carries.
    assign pre = op_i[OP_W-1] ? {1'b0, lg_res} : {ar_cy, ar_res};

    opsel_alu_gate #(.W(W+1)) u_gate (
        .d_i(pre), .en_i(out_en_i), .q_o(gated)
    );

    assign cy_o  = gated[W];
    assign res_o = gated[W-1:0];
endmodule

// Checker for opsel_alu: invariants between ports that hold for any
// input state, checked immediately since the block has no clock.
module opsel_alu_chk
    import opsel_alu_pkg::*;
#(
    parameter int W = 8
) (
    input logic [W-1:0]    opa_i,
    input logic [W-1:0]    opb_i,
    input logic [OP_W-1:0] op_i,
    input logic            out_en_i,
    input logic [W-1:0]    res_o,
    input logic            cy_o
);
    // Port-level invariants.
    always_comb begin
        a_r8_gate_zero: assert (out_en_i || ({cy_o, res_o} == '0))
            else $error("disabled output not zero");
        a_r1_add_sum: assert (!(out_en_i && op_i == 4'd0)
                              || ({cy_o, res_o} == ({1'b0, opa_i} + {1'b0, opb_i})))
            else $error("add mismatch");
        a_r2_sub_borrow: assert (!(out_en_i && op_i == 4'd1) || (cy_o == (opa_i < opb_i)))
            else $error("borrow mismatch");
        a_r4_div_by_zero: assert (!(out_en_i && (op_i == 4'd3 || op_i == 4'd4) && opb_i == '0)
                                  || (res_o == {W{1'b1}} && !cy_o))
            else $error("divide by zero result");
        a_r7_logic_no_carry: assert (!op_i[OP_W-1] || !cy_o)
            else $error("logic group carried");
    end
endmodule

bind opsel_alu opsel_alu_chk #(.W(W)) chk_i (
    .opa_i(opa_i), .opb_i(opb_i), .op_i(op_i), .out_en_i(out_en_i),
    .res_o(res_o), .cy_o(cy_o)
);

// File: tb/opsel_alu_tb_top.sv
// Scoreboard bench: driver applies stimulus on rising edges and queues
// expected values; monitor compares on falling edges.
module opsel_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opa = '0, opb = '0;
    logic [3:0] op = '0;
    logic       oe = 1'b0;
    logic [7:0] res;
    logic       cy;

    typedef struct {
        logic [8:0] exp;
        logic [3:0] op;
        logic [7:0] a, b;
        logic       oe;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    opsel_alu dut_i (
        .opa_i(opa), .opb_i(opb), .op_i(op), .out_en_i(oe),
        .res_o(res), .cy_o(cy)
    );

    // Reference model built from the requirements.
    function automatic logic [8:0] ref_of(logic [3:0] c, logic [7:0] a, logic [7:0] b, logic e);
        logic [8:0] r;
        case (c)
            4'd0: r = {1'b0, a} + {1'b0, b};
            4'd1: r = {(a < b), 8'(a - b)};
            4'd2: r = {1'b0, 8'(a * b)};
            4'd3: r = (b == 0) ? 9'h0FF : {1'b0, 8'(a / b)};
            4'd4: r = (b == 0) ? 9'h0FF : {1'b0, 8'(a % b)};
            4'd5: r = {(a == 8'hFF), 8'(a + 8'd1)};
            4'd6: r = {(a == 8'h00), 8'(a - 8'd1)};
            4'd7: r = {1'b0, a[6:0], 1'b0};
            4'd8: r = {1'b0, a & b};
            4'd9: r = {1'b0, a | b};
            4'd10: r = {1'b0, ~a};
            4'd11: r = {1'b0, a ^ b};
            4'd12: r = {1'b0, ~(a & b)};
            4'd13: r = {1'b0, ~(a | b)};
            4'd14: r = {1'b0, ~(a ^ b)};
            default: r = {1'b0, 1'b0, a[7:1]};
        endcase
        return e ? r : 9'h000;
    endfunction

    function automatic string req_of(item_t it);
        if (!it.oe) return "R8";
        if ((it.op == 3 || it.op == 4) && it.b == 0) return "R4";
        case (it.op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5, 4'd6: return "R5";
            4'd7, 4'd15: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Driver: apply one operation per cycle and queue its expectation.
    task automatic drive(logic [3:0] c, logic [7:0] a, logic [7:0] b, logic e);
        item_t it;
        @(posedge clk);
        op = c; opa = a; opb = b; oe = e;
        it.exp = ref_of(c, a, b, e);
        it.op = c; it.a = a; it.b = b; it.oe = e;
        q.push_back(it);
    endtask

    // Monitor: compare settled outputs half a cycle after each drive.
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_cmp++;
            if ({cy, res} !== it.exp) begin
                n_bad++;
                $display("FAIL %s op=%0d a=%h b=%h oe=%b: got cy=%b res=%h, expected cy=%b res=%h",
                         req_of(it), it.op, it.a, it.b, it.oe, cy, res, it.exp[8], it.exp[7:0]);
            end
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] corner [3];
        corner[0] = 8'h00; corner[1] = 8'h80; corner[2] = 8'hFF;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: enable low after reset gives zero outputs (R8).
        drive(4'd0, 8'hFF, 8'h01, 1'b0);
        // Corner sweep of every code (R1..R7), divide by zero (R4).
        for (int c = 0; c < 16; c++)
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3; j++)
                    drive(4'(c), corner[i], corner[j], 1'b1);
        // Wrap and carry edges: R1 carry, R2 borrow, R5 inc/dec.
        drive(4'd0, 8'hFF, 8'h01, 1'b1);
        drive(4'd1, 8'h00, 8'h01, 1'b1);
        drive(4'd5, 8'hFF, 8'h00, 1'b1);
        drive(4'd6, 8'h00, 8'h00, 1'b1);
        drive(4'd3, 8'h07, 8'h02, 1'b1);
        drive(4'd4, 8'h07, 8'h02, 1'b1);
        // Same sweep with enable low: gate beats carry and div0 (R8).
        for (int c = 0; c < 16; c++)
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3; j++)
                    drive(4'(c), corner[i], corner[j], 1'b0);
        // Random operands, codes and enable.
        for (int k = 0; k < 600; k++)
            drive(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
                  ($urandom_range(0, 7) != 0));
        @(posedge clk);
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule